// File: doc/BRIEF.md
# Parking Round-Robin Bus Arbiter

A central arbiter for a bus shared by several masters. Every master has one request line, one "finished" line and one grant line. A master asserts its request and waits for its grant. While granted it owns the bus, and it pulses its finished line in its last cycle of use. The arbiter computes the next owner in every cycle from the live requests, using rotating priority that starts just after the current owner. When the owner signals that it is finished, the grant moves on the very next clock edge, so no cycle is lost between owners.

When no other master is waiting, the grant stays where it is (the bus is parked). The parked owner can begin a new tenure by raising its request again, without arbitrating. An owner that keeps the bus for `MAX_TENURE` cycles while another master waits loses its grant. This bounds the wait of any requester. All pins are plain level control signals. No data passes through the block, so there is no valid/ready interface and no back-pressure.

Top module: `bus_arbiter_park`

## Requirements
- R1: Exactly one bit of `bus_gnt` is high in every cycle. During reset and in the first cycle after it, the grant sits on master 0 (`bus_gnt` = 1).
- R2: The grant only moves to a master whose `bus_req` bit was high in the cycle before the move.
- R3: An active owner keeps its grant until it pulses its own `bus_done` bit or reaches the tenure limit. A `bus_done` pulse from a master that does not hold the grant has no effect.
- R4: When the owner pulses `bus_done` and another master is requesting, the new grant appears on the next clock edge.
- R5: When no master other than the current owner requests, the grant does not change, including after the owner's `bus_done`. A parked owner that raises its request again keeps the grant.
- R6: The next owner is the first requesting master found by scanning upward from current owner index + 1, wrapping to index 0. The owner itself is excluded from this scan.
- R7: An owner that has held an active tenure for `MAX_TENURE` cycles while another master requests loses its grant at the end of that cycle. With no other requester it keeps the grant.
- R8: A parked owner whose own request is low hands the grant to a requesting master on the next edge.
- R9: A master that holds its request high continuously is granted within (N_MASTERS-1)*(MAX_TENURE+1)+2 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | N_MASTERS | Request line per master |
| bus_done | input | N_MASTERS | Per-master pulse marking the last cycle of its use |
| bus_gnt | output | N_MASTERS | One-hot grant per master |

## Verification
Directed sequences first take the grant from a parked master 0 to a single requester. They then hold a tenure while a stray `bus_done` arrives from a non-owner, hand over on release, and park with no other requester. These cases separate parking from release-driven handover and from revocation. A round-robin case with requesters on both sides of the owner tests the wrap of the scan. A non-releasing owner with a rival waiting isolates the tenure limit. A long random phase with persistent, randomly toggled requests and random releases compares every cycle against a reference model and tracks the longest continuous wait, which tests the starvation bound.

// File: rtl/arb_pkg.sv
package arb_pkg;
  // index reached by stepping k places past base in a ring of n entries
  function automatic int ring_step(input int base, input int k, input int n);
    return (base + k) % n;
  endfunction
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N_MASTERS = 4,
  localparam int IW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic [N_MASTERS-1:0] req,
  input  logic [IW-1:0]        cur,
  output logic [IW-1:0]        pick,
  output logic                 found
);
  import arb_pkg::*;

  always_comb begin
    found = 1'b0;
    pick  = cur;
    for (int k = 1; k < N_MASTERS; k++) begin
      int idx;
      idx = ring_step(int'(cur), k, N_MASTERS);
      if (!found && req[idx]) begin
        found = 1'b1;
        pick  = IW'(idx);
      end
    end
  end
endmodule

// File: rtl/tenure_timer.sv
module tenure_timer #(
  parameter int MAX_TENURE = 8,
  localparam int CW = (MAX_TENURE > 1) ? $clog2(MAX_TENURE) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic expired
);
  logic [CW-1:0] cnt_q;

  assign expired = (cnt_q == CW'(MAX_TENURE - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (restart)         cnt_q <= '0;
    else if (run && !expired) cnt_q <= cnt_q + 1'b1;
  end

  // R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= MAX_TENURE - 1);

  // R7
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
endmodule

// File: rtl/bus_arbiter_park.sv
module bus_arbiter_park #(
  parameter int N_MASTERS  = 4,
  parameter int MAX_TENURE = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] bus_req,
  input  logic [N_MASTERS-1:0] bus_done,
  output logic [N_MASTERS-1:0] bus_gnt
);
  localparam int IW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1;

  logic [IW-1:0] owner_q;
  logic          active_q;
  logic [IW-1:0] next_id;
  logic          next_ok;
  logic          expired;
  logic          own_req, own_done, rivals;
  logic          hand_over, begin_tenure;

  // decode owner into one grant line per master
  for (genvar g = 0; g < N_MASTERS; g++) begin : g_gnt
    assign bus_gnt[g] = (owner_q == IW'(g));
  end

  assign own_req  = bus_req[owner_q];
  assign own_done = bus_done[owner_q];
  assign rivals   = |(bus_req & ~bus_gnt);

  rr_pick #(.N_MASTERS(N_MASTERS)) u_pick (
    .req   (bus_req),
    .cur   (owner_q),
    .pick  (next_id),
    .found (next_ok)
  );

  assign hand_over    = next_ok &&
                        ((active_q && (own_done || expired)) ||
                         (!active_q && !own_req));
  assign begin_tenure = !active_q && own_req;

  tenure_timer #(.MAX_TENURE(MAX_TENURE)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (hand_over || begin_tenure),
    .run     (active_q),
    .expired (expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q  <= '0;
      active_q <= 1'b0;
    end else if (hand_over) begin
      owner_q  <= next_id;
      active_q <= 1'b1;
    end else if (active_q && own_done) begin
      active_q <= 1'b0;
    end else if (begin_tenure) begin
      active_q <= 1'b1;
    end
  end

  // R1
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bus_gnt) == 1);

  // R2
  gnt_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (bus_gnt == $past(bus_gnt)) || (|(bus_gnt & $past(bus_req))));

  // R3
  tenure_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !own_done && !expired) |=> $stable(bus_gnt));

  // R5
  park_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rivals |=> $stable(bus_gnt));

  // R6
  pick_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    next_ok |-> (bus_req[next_id] && (next_id != owner_q)));

  // R4
  handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && own_done && rivals) |=> !$stable(bus_gnt));
endmodule

// File: tb/bus_arbiter_park_test.sv
module bus_arbiter_park_test;
  localparam int N   = 4;
  localparam int MAX = 4;
  localparam int BOUND = (N - 1) * (MAX + 1) + 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] done = '0;
  logic [N-1:0] gnt;

  int checks = 0;
  int errors = 0;

  int m_owner = 0;
  bit m_active = 1'b0;
  int m_cnt = 0;
  int wait_cnt [N];
  int max_wait = 0;

  always #4 clk = ~clk;

  bus_arbiter_park #(.N_MASTERS(N), .MAX_TENURE(MAX)) uut (
    .clk(clk), .rst_n(rst_n), .bus_req(req), .bus_done(done), .bus_gnt(gnt)
  );

  function automatic logic [N-1:0] onehot(input int i);
    return (N)'(1) << i;
  endfunction

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: bus_gnt actual %b expected %b", tag, act, exp);
    end
  endtask

  // reference model written from the requirements
  task automatic model_tick(input logic [N-1:0] rq, input logic [N-1:0] dn);
    bit others, oreq, odn, lim, mv, st;
    int nxt;
    others = |(rq & ~onehot(m_owner));
    oreq = rq[m_owner];
    odn  = dn[m_owner];
    lim  = (m_cnt == MAX - 1);
    mv   = others && ((m_active && (odn || lim)) || (!m_active && !oreq));
    st   = !m_active && oreq;
    nxt  = m_owner;
    for (int k = N - 1; k >= 1; k--)
      if (rq[(m_owner + k) % N]) nxt = (m_owner + k) % N;
    if (mv || st) m_cnt = 0;
    else if (m_active && m_cnt < MAX - 1) m_cnt++;
    if (mv) begin
      m_owner = nxt;
      m_active = 1'b1;
    end else if (m_active && odn) m_active = 1'b0;
    else if (st) m_active = 1'b1;
  endtask

  task automatic step(input logic [N-1:0] rq, input logic [N-1:0] dn, input string tag);
    @(negedge clk);
    req = rq;
    done = dn;
    model_tick(rq, dn);
    @(posedge clk);
    #1;
    check(tag, gnt, onehot(m_owner));
    for (int i = 0; i < N; i++) begin
      if (req[i] && !gnt[i]) wait_cnt[i]++;
      else wait_cnt[i] = 0;
      if (wait_cnt[i] > max_wait) max_wait = wait_cnt[i];
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] rq;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < N; i++) wait_cnt[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 in reset", gnt, 4'b0001);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1 after reset", gnt, 4'b0001);

    // R8 and R2: parked master 0 idle, master 2 asks
    step(4'b0100, 4'b0000, "R8 move from parked");
    check("R2 granted requester", gnt, 4'b0100);
    // R3: master 1 waits, stray done from master 1
    step(4'b0110, 4'b0000, "R3 hold");
    step(4'b0110, 4'b0010, "R3 foreign done ignored");
    check("R3 still master 2", gnt, 4'b0100);
    // R4: release hands over on next edge
    step(4'b0010, 4'b0100, "R4 handover");
    check("R4 master 1 granted", gnt, 4'b0010);
    // R5: release with nobody else waiting parks
    step(4'b0000, 4'b0010, "R5 park after done");
    step(4'b0000, 4'b0000, "R5 parked");
    step(4'b0010, 4'b0000, "R5 parked owner resumes");
    check("R5 master 1 kept", gnt, 4'b0010);
    // R6: requesters 0 and 3 around owner 1, scan picks 3
    step(4'b1011, 4'b0000, "R6 wait");
    step(4'b1001, 4'b0010, "R6 pick upward");
    check("R6 master 3", gnt, 4'b1000);
    step(4'b0101, 4'b1000, "R6 wrap");
    check("R6 wrap to master 0", gnt, 4'b0001);
    // R7: master 0 never releases while master 2 waits
    for (int c = 0; c < MAX + 2; c++) step(4'b0101, 4'b0000, "R7 tenure limit");
    check("R7 revoked to master 2", gnt, 4'b0100);
    // R7: no rival, owner keeps past the limit
    for (int c = 0; c < MAX + 3; c++) step(4'b0100, 4'b0000, "R7 no rival keeps");
    check("R7 master 2 kept", gnt, 4'b0100);
    step(4'b0000, 4'b0100, "R5 release");

    // random phase
    rq = '0;
    max_wait = 0;
    for (int i = 0; i < N; i++) wait_cnt[i] = 0;
    for (int c = 0; c < 3000; c++) begin
      logic [N-1:0] dn;
      for (int i = 0; i < N; i++)
        if ($urandom % 6 == 0) rq[i] = ~rq[i];
      dn = '0;
      if ($urandom % 4 == 0) dn = onehot(m_owner);
      if ($urandom % 8 == 0) dn[$urandom % N] = 1'b1;
      step(rq, dn, "R6 R7 random");
    end
    checks++;
    if (max_wait > BOUND) begin
      errors++;
      $display("FAIL R9: longest wait actual %0d expected <= %0d", max_wait, BOUND);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule